// File: doc/BRIEF.md
# Dual Converter I/O Port Controller

This block sits on an 8-bit ISA-style I/O bus as a slave. It lets a host drive two byte-wide analog-to-digital converters. The host gives a 10-bit I/O address with an active-low read or write strobe. The block decodes six ports inside one eight-byte window. For each converter it turns the bus strobes into three separate control signals: a start-conversion pulse, a result read-enable and a status read-enable.

Each converter raises a busy flag while it converts. The block brings that flag into its own clock domain through a short synchronizer. A status read returns the flag on data bit 0, with every other bit at zero. Software writes the start port, polls the status port until bit 0 reads 0, and then reads the data port. The converter-side strobes are combinational, so each one is low for exactly as long as the matching bus strobe.

The read data leaves the block as a value (`io_dout`) plus a pad enable (`io_doe`). The pad ring turns this pair into the tri-stated data lines. When the enable is low, the lines float.

Top module: `dual_adc_isa_port`

## Requirements
- R1: While `rst_n` is low, every converter strobe stays high and `io_doe` stays low, whatever the bus does. The synchronized busy flags reset to 1.
- R2: A port is decoded only when `io_addr[9:3]` equals `BASE_ADDR[9:3]` (default 0x300). Within the window, `io_addr[0]` selects the converter (0 = first, 1 = second) and `io_addr[2:1]` selects the function: 00 start, 01 data, 10 status. Offsets 6 and 7 (`io_addr[2:1]` = 11) are not decoded.
- R3: A write (`io_wr_n` low) to a start port drives `conv_start_n[sel]` low for exactly the time `io_wr_n` is low. A write never enables the data output.
- R4: A read (`io_rd_n` low) of a data port drives `conv_rd_n[sel]` low and `io_doe` high. `io_dout` then equals `conv_data[8*sel +: 8]`.
- R5: A read of a status port drives `conv_stat_n[sel]` low and `io_doe` high. `io_dout` is then `{7'b0, flag}`, where flag is `conv_busy[sel]` delayed by `SYNC_STAGES` clocks (default 2).
- R6: The polling sequence works end to end. After a start, status reads 1 while the converter is busy. It reads 0 once the converter has finished. A data read then returns the new result.
- R7: At most one converter strobe is active at any time. An access to one converter leaves the other converter's strobes high.
- R8: The following accesses have no effect: writes to data or status ports, reads of start ports, and any access to offsets 6 or 7. No strobe goes low and `io_doe` stays low.
- R9: `io_doe` is low whenever `io_rd_n` is high. If `io_rd_n` and `io_wr_n` are low together, no strobe goes low and `io_doe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the busy-flag synchronizer |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 10 | I/O address bits 9..0 |
| io_rd_n | input | 1 | Active-low I/O read strobe |
| io_wr_n | input | 1 | Active-low I/O write strobe |
| io_dout | output | 8 | Read data toward the bus |
| io_doe | output | 1 | Pad enable for io_dout (low = lines float) |
| conv_start_n | output | 2 | Active-low start-conversion pulse per converter |
| conv_rd_n | output | 2 | Active-low result read-enable per converter |
| conv_stat_n | output | 2 | Active-low status read-enable per converter |
| conv_data | input | 16 | Converter results, converter 1 in bits 15..8 |
| conv_busy | input | 2 | Asynchronous busy (interrupt) flag per converter |

## Verification
Assertions check the following on every cycle:
- quiet outputs in reset;
- that each strobe is covered by the matching bus strobe;
- that at most one strobe is active;
- that the output is disabled outside reads;
- that status reads carry zero upper bits;
- that nothing is decoded outside the window.

Only the bench scenarios can show whether the right converter and function answer to each address. They also show that data reads return the converter's value and that the busy flag reaches bit 0 after the synchronizer delay. Finally, they show that a full start–poll–read sequence returns the result of the conversion that was just started.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
  localparam int NCONV = 2;
  localparam int DW    = 8;
  localparam int AW    = 10;
  localparam int OFFW  = 3;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_DATA  = 2'b01,
    OP_STAT  = 2'b10,
    OP_NONE  = 2'b11
  } port_op_e;

  typedef struct packed {
    logic     hit;
    port_op_e op;
    logic     sel;
  } dec_t;
endpackage

// File: rtl/isa_io_decode.sv
module isa_io_decode
  import dadc_pkg::*;
#(
  parameter logic [AW-1:0] BASE_ADDR = 10'h300
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  logic     in_window;
  port_op_e op_raw;

  always_comb begin
    in_window = (addr[AW-1:OFFW] == BASE_ADDR[AW-1:OFFW]);
    op_raw    = port_op_e'(addr[2:1]);
    dec.sel   = addr[0];
    dec.op    = in_window ? op_raw : OP_NONE;
    dec.hit   = in_window && (op_raw != OP_NONE);
  end
endmodule

// File: rtl/adc_strobe_gen.sv
module adc_strobe_gen
  import dadc_pkg::*;
(
  input  logic             rst_n,
  input  dec_t             dec,
  input  logic             io_rd_n,
  input  logic             io_wr_n,
  output logic [NCONV-1:0] start_n,
  output logic [NCONV-1:0] rd_n,
  output logic [NCONV-1:0] stat_n,
  output logic             rd_cycle
);
  logic wr_cycle;

  always_comb begin
    rd_cycle = rst_n && !io_rd_n && io_wr_n && dec.hit;
    wr_cycle = rst_n && !io_wr_n && io_rd_n && dec.hit;
  end

  for (genvar g = 0; g < NCONV; g++) begin : g_conv
    always_comb begin
      start_n[g] = !(wr_cycle && dec.op == OP_START && dec.sel == 1'(g));
      rd_n[g]    = !(rd_cycle && dec.op == OP_DATA  && dec.sel == 1'(g));
      stat_n[g]  = !(rd_cycle && dec.op == OP_STAT  && dec.sel == 1'(g));
    end
  end
endmodule

// File: rtl/adc_flag_sync.sv
module adc_flag_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (STAGES == 0) begin : g_pass
    assign q = d;
  end else begin : g_chain
    logic [STAGES-1:0][W-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0:0], d};
    end
    assign q = chain[STAGES-1];
  end
endmodule

// File: rtl/isa_read_mux.sv
module isa_read_mux
  import dadc_pkg::*;
(
  input  dec_t                rd_dec,
  input  logic                rd_cycle,
  input  logic [NCONV*DW-1:0] conv_data,
  input  logic [NCONV-1:0]    flags,
  output logic [DW-1:0]       dout,
  output logic                doe
);
  logic [DW-1:0] sel_data;

  always_comb begin
    sel_data = conv_data[rd_dec.sel*DW +: DW];
    doe      = rd_cycle && (rd_dec.op == OP_DATA || rd_dec.op == OP_STAT);
    dout     = '0;
    if (doe) begin
      if (rd_dec.op == OP_DATA) dout = sel_data;
      else                      dout = {{(DW-1){1'b0}}, flags[rd_dec.sel]};
    end
  end
endmodule

// File: rtl/dual_adc_isa_port.sv
module dual_adc_isa_port
  import dadc_pkg::*;
#(
  parameter logic [AW-1:0] BASE_ADDR   = 10'h300,
  parameter int            SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       io_addr,
  input  logic                io_rd_n,
  input  logic                io_wr_n,
  output logic [DW-1:0]       io_dout,
  output logic                io_doe,
  output logic [NCONV-1:0]    conv_start_n,
  output logic [NCONV-1:0]    conv_rd_n,
  output logic [NCONV-1:0]    conv_stat_n,
  input  logic [NCONV*DW-1:0] conv_data,
  input  logic [NCONV-1:0]    conv_busy
);
  dec_t             dec;
  logic             rd_cycle;
  logic [NCONV-1:0] flags;

  isa_io_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
    .addr (io_addr),
    .dec  (dec)
  );

  adc_strobe_gen u_stb (
    .rst_n    (rst_n),
    .dec      (dec),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .start_n  (conv_start_n),
    .rd_n     (conv_rd_n),
    .stat_n   (conv_stat_n),
    .rd_cycle (rd_cycle)
  );

  adc_flag_sync #(.STAGES(SYNC_STAGES), .W(NCONV)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (conv_busy),
    .q     (flags)
  );

  isa_read_mux u_mux (
    .rd_dec    (dec),
    .rd_cycle  (rd_cycle),
    .conv_data (conv_data),
    .flags     (flags),
    .dout      (io_dout),
    .doe       (io_doe)
  );
endmodule

// File: rtl/dadc_checker.sv
module dadc_checker #(
  parameter logic [9:0] BASE_ADDR = 10'h300
) (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] io_addr,
  input logic       io_rd_n,
  input logic       io_wr_n,
  input logic [7:0] io_dout,
  input logic       io_doe,
  input logic [1:0] conv_start_n,
  input logic [1:0] conv_rd_n,
  input logic [1:0] conv_stat_n
);
  logic [5:0] act;
  assign act = ~{conv_stat_n, conv_rd_n, conv_start_n};

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (act == 6'b0 && !io_doe));

  // R3
  start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act[1:0] != 2'b0) |-> (!io_wr_n && io_rd_n && !io_doe));

  // R4
  read_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act[5:2] != 4'b0) |-> (!io_rd_n && io_wr_n && io_doe));

  // R5
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act[5:4] != 2'b0) |-> (io_dout[7:1] == 7'b0));

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) <= 1);

  // R9
  float_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_n |-> !io_doe);

  // R2
  outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr[9:3] != BASE_ADDR[9:3]) |-> (act == 6'b0 && !io_doe));
endmodule

bind dual_adc_isa_port dadc_checker #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_addr      (io_addr),
  .io_rd_n      (io_rd_n),
  .io_wr_n      (io_wr_n),
  .io_dout      (io_dout),
  .io_doe       (io_doe),
  .conv_start_n (conv_start_n),
  .conv_rd_n    (conv_rd_n),
  .conv_stat_n  (conv_stat_n)
);

// File: tb/tb_dual_adc_isa_port.sv
module tb_dual_adc_isa_port;
  localparam logic [9:0] BASE = 10'h300;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  io_addr = '0;
  logic        io_rd_n = 1'b1;
  logic        io_wr_n = 1'b1;
  logic [7:0]  io_dout;
  logic        io_doe;
  logic [1:0]  conv_start_n, conv_rd_n, conv_stat_n;
  logic [15:0] conv_data;
  logic [1:0]  conv_busy;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dual_adc_isa_port #(.BASE_ADDR(BASE), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .io_dout(io_dout), .io_doe(io_doe),
    .conv_start_n(conv_start_n), .conv_rd_n(conv_rd_n),
    .conv_stat_n(conv_stat_n), .conv_data(conv_data), .conv_busy(conv_busy)
  );

  // behavioural converter stub
  logic [1:0] st_q;
  logic [7:0] res [2];
  int         cnt [2];
  always_ff @(posedge clk) begin
    st_q <= conv_start_n;
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        conv_busy[i] <= 1'b0; cnt[i] <= 0; res[i] <= 8'h00; st_q[i] <= 1'b1;
      end else if (conv_start_n[i] && !st_q[i]) begin
        conv_busy[i] <= 1'b1;
        cnt[i]       <= 8 + int'($urandom % 8);
        res[i]       <= 8'($urandom);
      end else if (cnt[i] > 0) begin
        cnt[i] <= cnt[i] - 1;
        if (cnt[i] == 1) conv_busy[i] <= 1'b0;
      end
    end
  end
  assign conv_data = {conv_rd_n[1] ? 8'h00 : res[1], conv_rd_n[0] ? 8'h00 : res[0]};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {doe, stat[1:0], rd[1:0], start[1:0]} active high
  function automatic logic [6:0] exp_ports(logic [9:0] a, bit rd, bit wr);
    logic [6:0] e = '0;
    logic hit = (a[9:3] == BASE[9:3]) && (a[2:1] != 2'b11);
    int s = int'(a[0]);
    if (hit && wr && !rd && a[2:1] == 2'b00) e[s] = 1'b1;
    if (hit && rd && !wr && a[2:1] == 2'b01) begin e[2+s] = 1'b1; e[6] = 1'b1; end
    if (hit && rd && !wr && a[2:1] == 2'b10) begin e[4+s] = 1'b1; e[6] = 1'b1; end
    return e;
  endfunction

  function automatic logic [6:0] obs();
    return {io_doe, ~conv_stat_n, ~conv_rd_n, ~conv_start_n};
  endfunction

  logic [6:0] s_ports;
  logic [7:0] s_dout;

  task automatic bus_cycle(input logic [9:0] a, input bit rd, input bit wr, input string req);
    logic [6:0] e = exp_ports(a, rd, wr);
    @(negedge clk); io_addr = a;
    @(negedge clk); io_rd_n = !rd; io_wr_n = !wr;
    repeat (2) @(negedge clk);
    s_ports = obs(); s_dout = io_dout;
    chk(s_ports == e, req, 32'(s_ports), 32'(e));
    io_rd_n = 1'b1; io_wr_n = 1'b1;
    #1;
    chk(obs() == 7'b0, "R3 strobe ends with bus strobe", 32'(obs()), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    // R1: access attempted during reset
    io_addr = BASE; io_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(obs() == 7'b0, "R1 quiet in reset", 32'(obs()), 0);
    io_wr_n = 1'b1; io_rd_n = 1'b0; io_addr = BASE + 10'd4;
    @(negedge clk);
    chk(obs() == 7'b0, "R1 no read in reset", 32'(obs()), 0);
    io_rd_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    // R1: flag starts busy right after reset
    io_addr = BASE + 10'd4; io_rd_n = 1'b0; #1;
    chk(io_dout == 8'h01, "R1 flag reset value", 32'(io_dout), 1);
    io_rd_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);

    // R3 / R6 directed per converter
    for (int c = 0; c < 2; c++) begin
      int polls = 0;
      bus_cycle(BASE + 10'(c), 1'b0, 1'b1, "R3 start pulse");
      bus_cycle(BASE + 10'd4 + 10'(c), 1'b1, 1'b0, "R5 status strobe");
      chk(s_dout == 8'h01, "R6 busy after start", 32'(s_dout), 1);
      while (s_dout[0] && polls < 100) begin
        bus_cycle(BASE + 10'd4 + 10'(c), 1'b1, 1'b0, "R5 status strobe");
        polls++;
      end
      chk(s_dout == 8'h00 && conv_busy[c] == 1'b0, "R6 done flag", 32'(s_dout), 0);
      bus_cycle(BASE + 10'd2 + 10'(c), 1'b1, 1'b0, "R4 data strobe");
      chk(s_dout == res[c], "R4 R6 result", 32'(s_dout), 32'(res[c]));
    end

    // R8 ignored accesses
    bus_cycle(BASE + 10'd2, 1'b0, 1'b1, "R8 write to data port");
    bus_cycle(BASE + 10'd5, 1'b0, 1'b1, "R8 write to status port");
    bus_cycle(BASE + 10'd1, 1'b1, 1'b0, "R8 read of start port");
    bus_cycle(BASE + 10'd6, 1'b1, 1'b0, "R8 offset 6");
    bus_cycle(BASE + 10'd7, 1'b0, 1'b1, "R8 offset 7");
    // R9 both strobes together
    bus_cycle(BASE + 10'd2, 1'b1, 1'b1, "R9 both strobes");
    // R2 neighbouring windows
    bus_cycle(BASE + 10'd8, 1'b0, 1'b1, "R2 above window");
    bus_cycle(BASE - 10'd4, 1'b1, 1'b0, "R2 below window");

    // R5 flag follows input after sync delay, with no conversion running
    repeat (20) @(negedge clk);
    bus_cycle(BASE + 10'd5, 1'b1, 1'b0, "R5 status strobe");
    chk(s_dout == 8'h00, "R5 idle flag", 32'(s_dout), 0);

    // R7 constrained random accesses
    for (int i = 0; i < 300; i++) begin
      logic [9:0] a = ($urandom % 4 != 0) ? BASE + 10'($urandom % 8) : 10'($urandom);
      int m = int'($urandom % 4);
      bit rd = (m != 1);
      bit wr = (m == 1 || m == 2);
      bus_cycle(a, rd, wr, "R7 R2 random decode");
      if (s_ports[3:2] != 2'b0)
        chk(s_dout == res[a[0]], "R4 random data", 32'(s_dout), 32'(res[a[0]]));
      if (s_ports[5:4] != 2'b0)
        chk(s_dout[7:1] == 7'b0, "R5 random status upper", 32'(s_dout), 32'(s_dout[0]));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", total);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule